// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control registers of a processor core: a status word built from three separate fields, a backup copy of the previous status, a second-level backup status, a condition bit, two banked stack pointers and two backup program counters. Software reaches them through one index. Reads are combinational from a read index. Writes take effect on the rising clock edge when the write enable is high.

The core's general-register stack pointer (R15) lives outside this block. Its current value comes in on `sp_in`. The block can overwrite it through `sp_we` and `sp_wdata`, and that write lands on the same edge as the control write that caused it.

A stack-mode bit, status bit 7, selects which stack pointer is live in R15:
- In mode 0, R15 is the interrupt stack pointer. The user pointer is held in a banked slot.
- In mode 1, R15 is the user stack pointer. The interrupt pointer is held in the banked slot.

Accesses to either stack-pointer index are routed to R15 or to the banked slot according to the mode. A status write that flips the mode exchanges the two pointers automatically.

The mode is kept by a two-state machine:
- `ISP_LIVE` is stack mode 0 and is the reset state.
- `USP_LIVE` is stack mode 1.
- Transition `TO_USER` (`ISP_LIVE` to `USP_LIVE`) is taken on a status write with bit 7 set.
- Transition `TO_INTR` (`USP_LIVE` to `ISP_LIVE`) is taken on a status write with bit 7 clear.
- Any other cycle holds the state.

Top module: `ctl_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset the stack mode is 0, and indices 0, 1, 3, 4, 5, 6, 8 and 9 read zero.
- R2: Index 0 (status) reads `{16'b0, B[7], B[6], 5'b0, B[0], M, S6, 5'b0, C}`. Here B is the backup status byte, M the stack mode, S6 status bit 6 and C the condition bit.
- R3: A write to index 0 loads the backup status byte from data bits 15:8 and the status byte from bits 7:0. It sets the stack mode from bit 7 and the condition bit from bit 0.
- R4: Index 1 reads the condition bit in bit 0, with zeros above it. A write to index 1 changes only the condition bit, taking it from data bit 0.
- R5: Index 2 (interrupt SP) reads `sp_in`, and a write to it drives `sp_we`=1 with `sp_wdata` equal to the data, while the mode is 0. While the mode is 1 it reads and writes the banked slot with `sp_we`=0. Index 3 (user SP) behaves the same way with the modes swapped.
- R6: A write to index 0 with bit 7 = 1 while the mode is 0 saves `sp_in` into the interrupt slot. In the same cycle it drives `sp_we`=1 with `sp_wdata` equal to the user slot's old value.
- R7: A write to index 0 with bit 7 = 0 while the mode is 1 saves `sp_in` into the user slot. In the same cycle it drives `sp_wdata` equal to the interrupt slot's old value, with `sp_we`=1.
- R8: A write to index 0 that leaves bit 7 unchanged performs no exchange and keeps `sp_we` at 0.
- R9: Index 6 (backup PC) and index 9 (second-level backup PC) take a full 32-bit write and read back with bit 0 forced to 0.
- R10: Index 8 (second-level backup status) takes an 8-bit write from bits 7:0 and reads back that byte masked with 0xC1.
- R11: Indices 4 and 5 are plain 32-bit storage that reads back exactly what was written.
- R12: Index 7 and indices 10 to 15 read zero. Writes to them change no register and keep `sp_we` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Control register index for the read port |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Write enable for the control register write port |
| wr_idx | input | 4 | Control register index for the write port |
| wr_data | input | 32 | Write data |
| sp_in | input | 32 | Current value of the general-register stack pointer R15 |
| sp_we | output | 1 | Requests a write of R15 on this clock edge |
| sp_wdata | output | 32 | Value to write into R15 |

## Verification
A status write that flips the stack mode falls in the same cycle as the stack-pointer exchange. On that one edge the block must capture the new status fields, save `sp_in` into one slot, and present the other slot's old value on `sp_wdata`. The bench provokes this by writing the status word with bit 7 toggled in both directions. It keeps its own R15 register, which it updates from `sp_we`. Before the edge it judges `sp_we` and `sp_wdata`. After the edge it reads both stack-pointer indices, and the saved slot and the new R15 value must both be right. Status writes that keep bit 7 unchanged are checked to leave R15 untouched.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

    // Stack mode: which stack pointer currently lives in R15.
    typedef enum logic {
        ISP_LIVE = 1'b0,
        USP_LIVE = 1'b1
    } stk_mode_t;

    // Control register indices.
    localparam int unsigned CR_STAT    = 0;
    localparam int unsigned CR_COND    = 1;
    localparam int unsigned CR_ISP     = 2;
    localparam int unsigned CR_USP     = 3;
    localparam int unsigned CR_GP_BASE = 4;
    localparam int unsigned CR_BPC     = 6;
    localparam int unsigned CR_BBST    = 8;
    localparam int unsigned CR_BBPC    = 9;

    // Bit positions inside the status word.
    localparam int unsigned ST_MODE_BIT = 7;
    localparam int unsigned ST_KEEP_BIT = 6;
    localparam int unsigned ST_COND_BIT = 0;
    localparam int unsigned ST_BK_LSB   = 8;

endpackage

// File: rtl/ctl_mode_fsm.sv
module ctl_mode_fsm
    import ctl_regfile_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      st_wr,
    input  logic      new_mode,
    output stk_mode_t mode,
    output logic      swap_in,
    output logic      swap_out
);

    stk_mode_t state_q;
    stk_mode_t state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISP_LIVE: if (st_wr && new_mode)  state_d = USP_LIVE;   // TO_USER
            USP_LIVE: if (st_wr && !new_mode) state_d = ISP_LIVE;   // TO_INTR
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ISP_LIVE;
        else     state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        swap_in  = 1'b0;
        swap_out = 1'b0;
        unique case (state_q)
            ISP_LIVE: swap_in  = st_wr && new_mode;
            USP_LIVE: swap_out = st_wr && !new_mode;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/ctl_bank_regs.sv
module ctl_bank_regs
    import ctl_regfile_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 4,
    parameter int N_GP  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [DW-1:0]            sp_in,
    input  stk_mode_t                mode,
    input  logic                     swap_in,
    input  logic                     swap_out,
    output logic [2:0]               bk_st_q,
    output logic                     keep6_q,
    output logic                     cond_q,
    output logic [DW-1:0]            isp_q,
    output logic [DW-1:0]            usp_q,
    output logic [N_GP-1:0][DW-1:0]  gp_q,
    output logic [DW-1:1]            bpc_q,
    output logic [2:0]               bbst_q,
    output logic [DW-1:1]            bbpc_q
);

    logic w_stat, w_cond, w_isp, w_usp, w_bpc, w_bbst, w_bbpc;

    assign w_stat = wr_en && (wr_idx == IDX_W'(CR_STAT));
    assign w_cond = wr_en && (wr_idx == IDX_W'(CR_COND));
    assign w_isp  = wr_en && (wr_idx == IDX_W'(CR_ISP)) && (mode == USP_LIVE);
    assign w_usp  = wr_en && (wr_idx == IDX_W'(CR_USP)) && (mode == ISP_LIVE);
    assign w_bpc  = wr_en && (wr_idx == IDX_W'(CR_BPC));
    assign w_bbst = wr_en && (wr_idx == IDX_W'(CR_BBST));
    assign w_bbpc = wr_en && (wr_idx == IDX_W'(CR_BBPC));

    // Status fields. Only the bits visible on read are stored.
    always_ff @(posedge clk) begin
        if (rst) begin
            bk_st_q <= '0;
            keep6_q <= 1'b0;
            cond_q  <= 1'b0;
        end else begin
            if (w_stat) begin
                bk_st_q <= {wr_data[ST_BK_LSB+7], wr_data[ST_BK_LSB+6], wr_data[ST_BK_LSB]};
                keep6_q <= wr_data[ST_KEEP_BIT];
            end
            if (w_stat || w_cond) cond_q <= wr_data[ST_COND_BIT];
        end
    end

    // Banked stack pointers.
    always_ff @(posedge clk) begin
        if (rst) begin
            isp_q <= '0;
            usp_q <= '0;
        end else begin
            if (swap_in)     isp_q <= sp_in;
            else if (w_isp)  isp_q <= wr_data;
            if (swap_out)    usp_q <= sp_in;
            else if (w_usp)  usp_q <= wr_data;
        end
    end

    // Backup program counters and second-level backup status.
    always_ff @(posedge clk) begin
        if (rst) begin
            bpc_q  <= '0;
            bbpc_q <= '0;
            bbst_q <= '0;
        end else begin
            if (w_bpc)  bpc_q  <= wr_data[DW-1:1];
            if (w_bbpc) bbpc_q <= wr_data[DW-1:1];
            if (w_bbst) bbst_q <= {wr_data[7], wr_data[6], wr_data[0]};
        end
    end

    // Plain scratch storage.
    for (genvar g = 0; g < N_GP; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (rst)
                gp_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(CR_GP_BASE + g)))
                gp_q[g] <= wr_data;
        end
    end

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux
    import ctl_regfile_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 4,
    parameter int N_GP  = 2
) (
    input  logic [IDX_W-1:0]         rd_idx,
    input  stk_mode_t                mode,
    input  logic [DW-1:0]            sp_in,
    input  logic [2:0]               bk_st_q,
    input  logic                     keep6_q,
    input  logic                     cond_q,
    input  logic [DW-1:0]            isp_q,
    input  logic [DW-1:0]            usp_q,
    input  logic [N_GP-1:0][DW-1:0]  gp_q,
    input  logic [DW-1:1]            bpc_q,
    input  logic [2:0]               bbst_q,
    input  logic [DW-1:1]            bbpc_q,
    output logic [DW-1:0]            rd_data
);

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_W'(CR_STAT): begin
                rd_data[ST_BK_LSB+7] = bk_st_q[2];
                rd_data[ST_BK_LSB+6] = bk_st_q[1];
                rd_data[ST_BK_LSB]   = bk_st_q[0];
                rd_data[ST_MODE_BIT] = (mode == USP_LIVE);
                rd_data[ST_KEEP_BIT] = keep6_q;
                rd_data[ST_COND_BIT] = cond_q;
            end
            IDX_W'(CR_COND): rd_data[0] = cond_q;
            IDX_W'(CR_ISP):  rd_data = (mode == ISP_LIVE) ? sp_in : isp_q;
            IDX_W'(CR_USP):  rd_data = (mode == USP_LIVE) ? sp_in : usp_q;
            IDX_W'(CR_BPC):  rd_data = {bpc_q, 1'b0};
            IDX_W'(CR_BBPC): rd_data = {bbpc_q, 1'b0};
            IDX_W'(CR_BBST): begin
                rd_data[7] = bbst_q[2];
                rd_data[6] = bbst_q[1];
                rd_data[0] = bbst_q[0];
            end
            default: rd_data = '0;
        endcase
        for (int g = 0; g < N_GP; g++) begin
            if (rd_idx == IDX_W'(CR_GP_BASE + g)) rd_data = gp_q[g];
        end
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_regfile_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 4,
    parameter int N_GP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    sp_in,
    output logic             sp_we,
    output logic [DW-1:0]    sp_wdata
);

    stk_mode_t               mode;
    logic                    swap_in, swap_out;
    logic [2:0]              bk_st_q, bbst_q;
    logic                    keep6_q, cond_q;
    logic [DW-1:0]           isp_q, usp_q;
    logic [N_GP-1:0][DW-1:0] gp_q;
    logic [DW-1:1]           bpc_q, bbpc_q;
    logic                    st_wr, live_wr;

    assign st_wr = wr_en && (wr_idx == IDX_W'(CR_STAT));

    ctl_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .st_wr    (st_wr),
        .new_mode (wr_data[ST_MODE_BIT]),
        .mode     (mode),
        .swap_in  (swap_in),
        .swap_out (swap_out)
    );

    ctl_bank_regs #(.DW(DW), .IDX_W(IDX_W), .N_GP(N_GP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sp_in    (sp_in),
        .mode     (mode),
        .swap_in  (swap_in),
        .swap_out (swap_out),
        .bk_st_q  (bk_st_q),
        .keep6_q  (keep6_q),
        .cond_q   (cond_q),
        .isp_q    (isp_q),
        .usp_q    (usp_q),
        .gp_q     (gp_q),
        .bpc_q    (bpc_q),
        .bbst_q   (bbst_q),
        .bbpc_q   (bbpc_q)
    );

    ctl_read_mux #(.DW(DW), .IDX_W(IDX_W), .N_GP(N_GP)) u_rd (
        .rd_idx   (rd_idx),
        .mode     (mode),
        .sp_in    (sp_in),
        .bk_st_q  (bk_st_q),
        .keep6_q  (keep6_q),
        .cond_q   (cond_q),
        .isp_q    (isp_q),
        .usp_q    (usp_q),
        .gp_q     (gp_q),
        .bpc_q    (bpc_q),
        .bbst_q   (bbst_q),
        .bbpc_q   (bbpc_q),
        .rd_data  (rd_data)
    );

    // Writes to the live stack pointer are forwarded to R15.
    assign live_wr = wr_en &&
                     (((wr_idx == IDX_W'(CR_ISP)) && (mode == ISP_LIVE)) ||
                      ((wr_idx == IDX_W'(CR_USP)) && (mode == USP_LIVE)));

    assign sp_we    = swap_in || swap_out || live_wr;
    assign sp_wdata = swap_in  ? usp_q :
                      swap_out ? isp_q : wr_data;

endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk #(
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] rd_idx,
    input logic [DW-1:0]    rd_data,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [DW-1:0]    wr_data,
    input logic [DW-1:0]    sp_in,
    input logic             sp_we,
    input logic [DW-1:0]    sp_wdata,
    input logic             stack_mode,
    input logic             cond,
    input logic [DW-1:0]    isp,
    input logic [DW-1:0]    usp
);

    logic st_wr;
    assign st_wr = wr_en && (wr_idx == IDX_W'(0));

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!stack_mode && !cond && isp == '0 && usp == '0));

    p_mode_load_r3: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> (stack_mode == $past(wr_data[7])));

    p_cond_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == IDX_W'(0) || wr_idx == IDX_W'(1))) |=> (cond == $past(wr_data[0])));

    p_enter_out_r6: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wr_data[7] && !stack_mode) |-> (sp_we && sp_wdata == usp));

    p_enter_save_r6: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wr_data[7] && !stack_mode) |=> (isp == $past(sp_in)));

    p_leave_out_r7: assert property (@(posedge clk) disable iff (rst)
        (st_wr && !wr_data[7] && stack_mode) |-> (sp_we && sp_wdata == isp));

    p_leave_save_r7: assert property (@(posedge clk) disable iff (rst)
        (st_wr && !wr_data[7] && stack_mode) |=> (usp == $past(sp_in)));

    p_no_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (st_wr && (wr_data[7] == stack_mode)) |-> !sp_we);

    p_pc_lsb_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(6) || rd_idx == IDX_W'(9)) |-> !rd_data[0]);

    p_bbst_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(8)) |-> ((rd_data & ~DW'(32'hC1)) == '0));

    p_unused_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(7) || rd_idx >= IDX_W'(10)) |-> (rd_data == '0));

endmodule

bind ctl_regfile ctl_regfile_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sp_in      (sp_in),
    .sp_we      (sp_we),
    .sp_wdata   (sp_wdata),
    .stack_mode (mode),
    .cond       (cond_q),
    .isp        (isp_q),
    .usp        (usp_q)
);

// File: tb/sim_ctl_regfile.sv
`timescale 1ns/1ps
module sim_ctl_regfile;

    localparam logic [31:0] R15_INIT = 32'hA5A5_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] r15;
    logic        sp_we;
    logic [31:0] sp_wdata;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Environment model of the general-register stack pointer.
    always @(posedge clk) begin
        if (rst)        r15 <= R15_INIT;
        else if (sp_we) r15 <= sp_wdata;
    end

    ctl_regfile u0 (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sp_in    (r15),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] idx, input logic [31:0] exp);
        rd_idx = idx;
        #1;
        chk(req, rd_data, exp);
    endtask

    // Write one register; check the R15 request seen before the edge.
    task automatic wr_chk(input string req, input logic [3:0] idx, input logic [31:0] data,
                          input logic exp_we, input logic [31:0] exp_wd);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        #1;
        chk({req, " sp_we"}, {31'b0, sp_we}, {31'b0, exp_we});
        if (exp_we) chk({req, " sp_wdata"}, sp_wdata, exp_wd);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 status", 4'd0, 32'h0);
        rd_chk("R1 cond", 4'd1, 32'h0);
        rd_chk("R1 usp", 4'd3, 32'h0);
        rd_chk("R1 gp4", 4'd4, 32'h0);
        rd_chk("R1 bpc", 4'd6, 32'h0);
        rd_chk("R1 bbst", 4'd8, 32'h0);
        rd_chk("R1 bbpc", 4'd9, 32'h0);
        rd_chk("R5 isp alias r15 mode0", 4'd2, R15_INIT);
    endtask

    task automatic t_status();
        wr_chk("R8 stat write keeps mode0", 4'd0, 32'h0000_FF41, 1'b0, 32'h0);
        rd_chk("R2 status assembly", 4'd0, 32'h0000_C141);
        rd_chk("R3 cond from bit0", 4'd1, 32'h1);
    endtask

    task automatic t_cond();
        wr_chk("R4 cond write", 4'd1, 32'hFFFF_FFFE, 1'b0, 32'h0);
        rd_chk("R4 cond cleared", 4'd1, 32'h0);
        rd_chk("R4 status other fields kept", 4'd0, 32'h0000_C140);
        wr_chk("R4 cond write", 4'd1, 32'h0000_0001, 1'b0, 32'h0);
        rd_chk("R4 cond set seen in status", 4'd0, 32'h0000_C141);
    endtask

    task automatic t_alias_mode0();
        wr_chk("R5 usp banked write", 4'd3, 32'h2222_0000, 1'b0, 32'h0);
        rd_chk("R5 usp banked read", 4'd3, 32'h2222_0000);
        rd_chk("R5 isp still r15", 4'd2, R15_INIT);
        wr_chk("R5 isp write to r15", 4'd2, 32'h1111_0000, 1'b1, 32'h1111_0000);
        rd_chk("R5 isp read r15", 4'd2, 32'h1111_0000);
        chk("R5 r15 updated", r15, 32'h1111_0000);
    endtask

    task automatic t_enter();
        wr_chk("R6 enter mode1 exchange", 4'd0, 32'h0000_0080, 1'b1, 32'h2222_0000);
        chk("R6 r15 from usp slot", r15, 32'h2222_0000);
        rd_chk("R6 isp slot saved r15", 4'd2, 32'h1111_0000);
        rd_chk("R5 usp alias r15 mode1", 4'd3, 32'h2222_0000);
        rd_chk("R3 status mode bit", 4'd0, 32'h0000_0080);
    endtask

    task automatic t_mode1();
        wr_chk("R5 usp write to r15", 4'd3, 32'h3333_0000, 1'b1, 32'h3333_0000);
        wr_chk("R5 isp banked write", 4'd2, 32'h4444_0000, 1'b0, 32'h0);
        rd_chk("R5 isp banked read", 4'd2, 32'h4444_0000);
        rd_chk("R5 usp read r15", 4'd3, 32'h3333_0000);
        wr_chk("R8 stat write keeps mode1", 4'd0, 32'h0000_0081, 1'b0, 32'h0);
        rd_chk("R8 status after keep", 4'd0, 32'h0000_0081);
        chk("R8 r15 untouched", r15, 32'h3333_0000);
    endtask

    task automatic t_leave();
        wr_chk("R7 leave mode1 exchange", 4'd0, 32'h0000_0000, 1'b1, 32'h4444_0000);
        chk("R7 r15 from isp slot", r15, 32'h4444_0000);
        rd_chk("R7 usp slot saved r15", 4'd3, 32'h3333_0000);
        rd_chk("R7 isp alias r15", 4'd2, 32'h4444_0000);
        rd_chk("R7 status", 4'd0, 32'h0);
    endtask

    task automatic t_pcs();
        wr_chk("R9 bpc write", 4'd6, 32'hFFFF_FFFF, 1'b0, 32'h0);
        rd_chk("R9 bpc lsb masked", 4'd6, 32'hFFFF_FFFE);
        wr_chk("R9 bbpc write", 4'd9, 32'h1234_5679, 1'b0, 32'h0);
        rd_chk("R9 bbpc lsb masked", 4'd9, 32'h1234_5678);
    endtask

    task automatic t_bbst();
        wr_chk("R10 bbst write", 4'd8, 32'hFFFF_FFFF, 1'b0, 32'h0);
        rd_chk("R10 bbst mask", 4'd8, 32'h0000_00C1);
        wr_chk("R10 bbst write", 4'd8, 32'h0000_003E, 1'b0, 32'h0);
        rd_chk("R10 bbst unmasked bits dropped", 4'd8, 32'h0);
    endtask

    task automatic t_gp();
        wr_chk("R11 gp4 write", 4'd4, 32'hCAFE_0001, 1'b0, 32'h0);
        wr_chk("R11 gp5 write", 4'd5, 32'h0BAD_0002, 1'b0, 32'h0);
        rd_chk("R11 gp4 read", 4'd4, 32'hCAFE_0001);
        rd_chk("R11 gp5 read", 4'd5, 32'h0BAD_0002);
    endtask

    task automatic t_unused();
        wr_chk("R12 idx7 write", 4'd7, 32'hDEAD_BEEF, 1'b0, 32'h0);
        wr_chk("R12 idx15 write", 4'd15, 32'hFFFF_FFFF, 1'b0, 32'h0);
        for (int i = 10; i < 16; i++) rd_chk("R12 unused reads zero", 4'(i), 32'h0);
        rd_chk("R12 idx7 reads zero", 4'd7, 32'h0);
        rd_chk("R12 gp4 untouched", 4'd4, 32'hCAFE_0001);
        rd_chk("R12 status untouched", 4'd0, 32'h0);
        rd_chk("R12 bpc untouched", 4'd6, 32'hFFFF_FFFE);
        rd_chk("R12 isp alias untouched", 4'd2, 32'h4444_0000);
        chk("R12 r15 untouched", r15, 32'h4444_0000);
    endtask

    task automatic t_reset_mid();
        wr_chk("R6 re-enter mode1", 4'd0, 32'h0000_FF80, 1'b1, 32'h3333_0000);
        apply_reset();
        rd_chk("R1 status after reset", 4'd0, 32'h0);
        rd_chk("R1 usp after reset", 4'd3, 32'h0);
        rd_chk("R1 mode0 after reset", 4'd2, R15_INIT);
        rd_chk("R1 gp5 after reset", 4'd5, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        apply_reset();
        t_reset();
        t_status();
        t_cond();
        t_alias_mode0();
        t_enter();
        t_mode1();
        t_leave();
        t_pcs();
        t_bbst();
        t_gp();
        t_unused();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule